// File: doc/BRIEF.md
# Per-Line GPIO Event Interrupt Controller

This block watches every input line of one GPIO bank and turns a chosen kind of activity on each line into an interrupt. For every line a 3-bit selector picks one of five detections: falling edge, rising edge, either edge, low level or high level. Each input first crosses into the clock domain through a two-flop synchronizer. It can then pass through an optional glitch filter, clocked by an external sample strobe. An edge is found by comparing the conditioned value with its value from the previous cycle.

Every detected event is latched in a per-line status register, whatever that line's mask bit holds. Reading the status address returns the latched bits and clears them in the same access. A per-line mask is set and cleared through two write-one addresses and can be read back at a third. The single interrupt output is high while any status bit is set whose mask bit is also set. The bus decode that selects this bank sits outside the block: the block sees a plain read or write strobe with a byte offset.

Top module: `gpio_event_irq`

## Requirements
- R1: Selector code 0 detects falling edges, code 1 rising edges and code 2 both edges. The status bit becomes visible on the third rising clock edge after the input changes.
- R2: Selector code 3 (low) and code 4 (high) set the status bit on every cycle the level is present, so a status read does not clear a level that is still present.
- R3: Selector codes 5, 6 and 7 never set a status bit.
- R4: A write to offset 0x20 sets the mask bits written as 1. Bits written as 0 leave the mask unchanged.
- R5: A write to offset 0x24 clears the mask bits written as 1. Bits written as 0 leave the mask unchanged.
- R6: A read at offset 0x28 returns the mask, with bit i belonging to line i.
- R7: A read at offset 0x2C returns the latched status, with bit i belonging to line i, and clears it in the same access.
- R8: An event detected in the same cycle as a status read is not lost. It appears in the next status read.
- R9: Events are latched whether or not the line is masked. irq is high exactly while some line has both its status bit and its mask bit set.
- R10: With a line's filter enabled, a pulse shorter than one strobe interval is rejected, and a level held over two consecutive strobes passes. With the filter disabled, a one-cycle pulse is detected.
- R11: After reset, the status and mask are all zero and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| line_in | input | NLINES | Asynchronous input lines |
| evt_sel | input | 3*NLINES | Event selector per line; line i uses bits 3i+2..3i |
| filt_en | input | NLINES | Per-line glitch filter enable |
| filt_tick | input | 1 | Filter sample strobe, one cycle wide |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Byte offset within the bank |
| wdata | input | NLINES | Write data |
| rdata | output | NLINES | Read data, valid in the cycle of rd_en |
| irq | output | 1 | Bank interrupt |

## Verification
The hardest situation to reach from the ports is an event that lands in the very cycle the status register is being read and cleared. The bench counts the synchronizer and edge-register stages to find the posedge where the detection is live. It raises a rising-edge line at a falling clock edge, waits exactly two cycles, and then issues the status read. That first read must come back empty and the following read must show the bit. The filter cases are also placed by cycle count against the bench's strobe period, so that a glitch can be sampled by at most one strobe.

// File: rtl/gpio_evt_pkg.sv
package gpio_evt_pkg;

    localparam int SEL_W  = 3;
    localparam int ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_MASK_SET = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_MASK_CLR = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_MASK_RD  = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 8'h2C;

    typedef enum logic [SEL_W-1:0] {
        EV_FALL = 3'd0,
        EV_RISE = 3'd1,
        EV_BOTH = 3'd2,
        EV_LOW  = 3'd3,
        EV_HIGH = 3'd4
    } evt_mode_e;

    typedef struct packed {
        logic mask_set;
        logic mask_clr;
        logic mask_rd;
        logic sts_rd;
    } bus_op_t;

    function automatic bus_op_t bus_decode(input logic wr, input logic rd,
                                           input logic [ADDR_W-1:0] a);
        bus_op_t op;
        op.mask_set = wr && (a == OFS_MASK_SET);
        op.mask_clr = wr && (a == OFS_MASK_CLR);
        op.mask_rd  = rd && (a == OFS_MASK_RD);
        op.sts_rd   = rd && (a == OFS_STATUS);
        return op;
    endfunction

    function automatic logic evt_match(input logic [SEL_W-1:0] sel,
                                       input logic cur, input logic prev);
        logic m;
        case (sel)
            EV_FALL: m = prev & ~cur;
            EV_RISE: m = ~prev & cur;
            EV_BOTH: m = prev ^ cur;
            EV_LOW:  m = ~cur;
            EV_HIGH: m = cur;
            default: m = 1'b0;
        endcase
        return m;
    endfunction

endpackage

// File: rtl/gpio_evt_cond.sv
module gpio_evt_cond #(
    parameter bit HAS_FILTER = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic din,
    input  logic filt_en,
    input  logic tick,
    output logic dout
);
    logic s1_q, s2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q <= 1'b0;
            s2_q <= 1'b0;
        end else begin
            s1_q <= din;
            s2_q <= s1_q;
        end
    end

    generate
        if (HAS_FILTER) begin : g_filt
            logic samp_q, filt_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    samp_q <= 1'b0;
                    filt_q <= 1'b0;
                end else if (!filt_en) begin
                    samp_q <= s2_q;
                    filt_q <= s2_q;
                end else if (tick) begin
                    samp_q <= s2_q;
                    if (s2_q == samp_q)
                        filt_q <= s2_q;
                end
            end
            assign dout = filt_en ? filt_q : s2_q;
        end else begin : g_raw
            logic unused_filt;
            assign unused_filt = filt_en ^ tick;
            assign dout = s2_q;
        end
    endgenerate
endmodule

// File: rtl/gpio_evt_detect.sv
module gpio_evt_detect
    import gpio_evt_pkg::*;
#(
    parameter int NLINES = 32,
    localparam int SELV_W = SEL_W * NLINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] clean,
    input  logic [SELV_W-1:0] sel,
    output logic [NLINES-1:0] hit
);
    logic [NLINES-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= clean;
    end

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_line
            assign hit[i] = evt_match(sel[SEL_W*i +: SEL_W], clean[i], prev_q[i]);
        end
    endgenerate
endmodule

// File: rtl/gpio_evt_regs.sv
module gpio_evt_regs
    import gpio_evt_pkg::*;
#(
    parameter int NLINES = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    input  logic [NLINES-1:0] hit,
    output logic [NLINES-1:0] rdata,
    output logic [NLINES-1:0] mask_q,
    output logic [NLINES-1:0] sts_q,
    output logic              irq
);
    bus_op_t op;
    assign op = bus_decode(wr_en, rd_en, addr);

    always_ff @(posedge clk) begin
        if (rst)              mask_q <= '0;
        else if (op.mask_set) mask_q <= mask_q | wdata;
        else if (op.mask_clr) mask_q <= mask_q & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) sts_q <= '0;
        else     sts_q <= (op.sts_rd ? '0 : sts_q) | hit;
    end

    always_comb begin
        rdata = '0;
        if (op.mask_rd)     rdata = mask_q;
        else if (op.sts_rd) rdata = sts_q;
    end

    assign irq = |(sts_q & mask_q);
endmodule

// File: rtl/gpio_event_irq.sv
module gpio_event_irq
    import gpio_evt_pkg::*;
#(
    parameter int NLINES     = 32,
    parameter bit HAS_FILTER = 1'b1,
    localparam int SELV_W    = SEL_W * NLINES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NLINES-1:0] line_in,
    input  logic [SELV_W-1:0] evt_sel,
    input  logic [NLINES-1:0] filt_en,
    input  logic              filt_tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [NLINES-1:0] wdata,
    output logic [NLINES-1:0] rdata,
    output logic              irq
);
    logic [NLINES-1:0] clean;
    logic [NLINES-1:0] hit;
    logic [NLINES-1:0] msk;
    logic [NLINES-1:0] sts;

    generate
        for (genvar i = 0; i < NLINES; i++) begin : g_cond
            gpio_evt_cond #(.HAS_FILTER(HAS_FILTER)) u_cond (
                .clk     (clk),
                .rst     (rst),
                .din     (line_in[i]),
                .filt_en (filt_en[i]),
                .tick    (filt_tick),
                .dout    (clean[i])
            );
        end
    endgenerate

    gpio_evt_detect #(.NLINES(NLINES)) u_det (
        .clk   (clk),
        .rst   (rst),
        .clean (clean),
        .sel   (evt_sel),
        .hit   (hit)
    );

    gpio_evt_regs #(.NLINES(NLINES)) u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .hit    (hit),
        .rdata  (rdata),
        .mask_q (msk),
        .sts_q  (sts),
        .irq    (irq)
    );
endmodule

// File: rtl/gpio_event_irq_chk.sv
module gpio_event_irq_chk
    import gpio_evt_pkg::*;
#(
    parameter int NLINES = 32,
    localparam int SELV_W = SEL_W * NLINES
) (
    input logic              clk,
    input logic              rst,
    input logic [SELV_W-1:0] evt_sel,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [NLINES-1:0] wdata,
    input logic [NLINES-1:0] rdata,
    input logic              irq,
    input logic [NLINES-1:0] hit,
    input logic [NLINES-1:0] msk,
    input logic [NLINES-1:0] sts
);
    logic [NLINES-1:0] bad_sel;
    always_comb begin
        for (int i = 0; i < NLINES; i++)
            bad_sel[i] = (evt_sel[SEL_W*i +: SEL_W] > 3'd4);
    end

    logic set_wr, clr_wr, msk_rd, sts_rd;
    assign set_wr = wr_en && (addr == OFS_MASK_SET);
    assign clr_wr = wr_en && (addr == OFS_MASK_CLR);
    assign msk_rd = rd_en && (addr == OFS_MASK_RD);
    assign sts_rd = rd_en && (addr == OFS_STATUS);

    assert_reset_clear_R11: assert property (@(posedge clk)
        rst |=> (msk == '0 && sts == '0));

    assert_bad_sel_quiet_R3: assert property (@(posedge clk) disable iff (rst)
        (hit & bad_sel) == '0);

    assert_mask_set_R4: assert property (@(posedge clk) disable iff (rst)
        set_wr |=> ((msk & $past(wdata)) == $past(wdata)));

    assert_mask_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(set_wr || clr_wr) |=> (msk == $past(msk)));

    assert_mask_clr_R5: assert property (@(posedge clk) disable iff (rst)
        clr_wr |=> ((msk & $past(wdata)) == '0));

    assert_mask_read_R6: assert property (@(posedge clk) disable iff (rst)
        msk_rd |-> (rdata == msk));

    assert_sts_clear_R7: assert property (@(posedge clk) disable iff (rst)
        sts_rd |=> (sts == $past(hit)));

    assert_sts_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        !sts_rd |=> ((sts & $past(sts)) == $past(sts)));

    assert_irq_masked_R9: assert property (@(posedge clk) disable iff (rst)
        (msk == '0) |-> !irq);
endmodule

bind gpio_event_irq gpio_event_irq_chk #(.NLINES(NLINES)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .evt_sel (evt_sel),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .addr    (addr),
    .wdata   (wdata),
    .rdata   (rdata),
    .irq     (irq),
    .hit     (hit),
    .msk     (msk),
    .sts     (sts)
);

// File: tb/sim_gpio_event_irq.sv
module sim_gpio_event_irq;
    import gpio_evt_pkg::*;

    localparam int N = 32;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [N-1:0]  line_in = '0;
    logic [3*N-1:0] evt_sel = '1;
    logic [N-1:0]  filt_en = '0;
    logic          filt_tick = 1'b0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [7:0]    addr = '0;
    logic [N-1:0]  wdata = '0;
    logic [N-1:0]  rdata;
    logic          irq;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    logic [N-1:0] rv;
    logic [2:0] tcnt = '0;

    gpio_event_irq #(.NLINES(N)) u0 (
        .clk(clk), .rst(rst), .line_in(line_in), .evt_sel(evt_sel),
        .filt_en(filt_en), .filt_tick(filt_tick), .wr_en(wr_en),
        .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    always #2 clk = ~clk;

    // strobe one cycle in eight, changed away from the active edge
    always @(negedge clk) begin
        tcnt = tcnt + 3'd1;
        filt_tick = (tcnt == 3'd0);
    end

    task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        rd_en = 1'b1; addr = a;
        #1 d = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic set_sel(input int ln, input logic [2:0] c);
        evt_sel[3*ln +: 3] = c;
    endtask

    task automatic t_reset();
        check("R11 irq", {31'b0, irq}, 32'h0);
        rd(OFS_MASK_RD, rv); check("R11 mask", rv, 32'h0);
        rd(OFS_STATUS, rv);  check("R11 status", rv, 32'h0);
    endtask

    task automatic t_edges();
        set_sel(3, 3'd0);
        line_in[3] = 1'b1; idle(4);
        rd(OFS_STATUS, rv); check("R1 rise ignored by falling mode", rv, 32'h0);
        wr(OFS_MASK_SET, 32'h8);
        line_in[3] = 1'b0;
        idle(2); check("R1 latency not yet", {31'b0, irq}, 32'h0);
        idle(1); check("R1 latency third edge", {31'b0, irq}, 32'h1);
        rd(OFS_STATUS, rv); check("R1 falling", rv, 32'h8);
        wr(OFS_MASK_CLR, 32'h8);
        set_sel(5, 3'd1);
        line_in[5] = 1'b1; idle(3);
        rd(OFS_STATUS, rv); check("R1 rising", rv, 32'h20);
        line_in[5] = 1'b0; idle(4);
        rd(OFS_STATUS, rv); check("R1 fall ignored by rising mode", rv, 32'h0);
        set_sel(7, 3'd2);
        line_in[7] = 1'b1; idle(3);
        rd(OFS_STATUS, rv); check("R1 both up", rv, 32'h80);
        line_in[7] = 1'b0; idle(3);
        rd(OFS_STATUS, rv); check("R1 both down", rv, 32'h80);
        set_sel(3, 3'd7); set_sel(7, 3'd7);
    endtask

    task automatic t_level();
        set_sel(9, 3'd3); idle(3);
        rd(OFS_STATUS, rv); check("R2 low level", rv, 32'h200);
        rd(OFS_STATUS, rv); check("R2 low persists after read", rv, 32'h200);
        line_in[9] = 1'b1; idle(3);
        rd(OFS_STATUS, rv);
        rd(OFS_STATUS, rv); check("R2 low gone", rv, 32'h0);
        set_sel(10, 3'd4); line_in[10] = 1'b1; idle(3);
        rd(OFS_STATUS, rv); check("R2 high level", rv, 32'h400);
        rd(OFS_STATUS, rv); check("R2 high persists after read", rv, 32'h400);
        line_in[10] = 1'b0; idle(3);
        rd(OFS_STATUS, rv);
        rd(OFS_STATUS, rv); check("R2 high gone", rv, 32'h0);
        set_sel(9, 3'd7); set_sel(10, 3'd7);
        line_in[9] = 1'b0; idle(4);
        rd(OFS_STATUS, rv);
    endtask

    task automatic t_bad_sel();
        set_sel(13, 3'd5); set_sel(14, 3'd6); set_sel(15, 3'd7);
        line_in[15:13] = 3'b111; idle(4);
        line_in[15:13] = 3'b000; idle(4);
        rd(OFS_STATUS, rv); check("R3 codes 5-7 silent", rv, 32'h0);
    endtask

    task automatic t_mask();
        wr(OFS_MASK_SET, 32'h0000_F0F0);
        rd(OFS_MASK_RD, rv); check("R4 R6 set", rv, 32'h0000_F0F0);
        wr(OFS_MASK_SET, 32'h0);
        rd(OFS_MASK_RD, rv); check("R4 zero write", rv, 32'h0000_F0F0);
        wr(OFS_MASK_SET, 32'h0100_0000);
        rd(OFS_MASK_RD, rv); check("R4 accumulate", rv, 32'h0100_F0F0);
        wr(OFS_MASK_CLR, 32'h0000_3030);
        rd(OFS_MASK_RD, rv); check("R5 clear", rv, 32'h0100_C0C0);
        wr(OFS_MASK_CLR, 32'h0);
        rd(OFS_MASK_RD, rv); check("R5 zero write", rv, 32'h0100_C0C0);
        wr(OFS_MASK_CLR, 32'hFFFF_FFFF);
        rd(OFS_MASK_RD, rv); check("R5 clear all", rv, 32'h0);
    endtask

    task automatic t_irq();
        line_in[5] = 1'b1; idle(3);
        check("R9 masked no irq", {31'b0, irq}, 32'h0);
        wr(OFS_MASK_SET, 32'h20);
        check("R9 irq after unmask", {31'b0, irq}, 32'h1);
        rd(OFS_STATUS, rv); check("R7 R9 latched while masked", rv, 32'h20);
        check("R7 irq drops after read", {31'b0, irq}, 32'h0);
        wr(OFS_MASK_CLR, 32'h20);
        line_in[5] = 1'b0; idle(4);
    endtask

    task automatic t_coincide();
        line_in[5] = 1'b1; idle(2);
        rd(OFS_STATUS, rv); check("R8 read before latch", rv, 32'h0);
        rd(OFS_STATUS, rv); check("R8 event kept", rv, 32'h20);
        line_in[5] = 1'b0; idle(4);
        rd(OFS_STATUS, rv);
    endtask

    task automatic t_filter();
        set_sel(12, 3'd1); filt_en[12] = 1'b1; idle(2);
        line_in[12] = 1'b1; idle(3); line_in[12] = 1'b0; idle(30);
        rd(OFS_STATUS, rv); check("R10 glitch rejected", rv, 32'h0);
        line_in[12] = 1'b1; idle(30);
        rd(OFS_STATUS, rv); check("R10 held level passes", rv, 32'h1000);
        line_in[12] = 1'b0; idle(30);
        rd(OFS_STATUS, rv);
        filt_en[12] = 1'b0; idle(2);
        line_in[12] = 1'b1; idle(1); line_in[12] = 1'b0; idle(4);
        rd(OFS_STATUS, rv); check("R10 bypass sees short pulse", rv, 32'h1000);
    endtask

    initial begin
        idle(5);
        rst = 1'b0;
        idle(2);
        t_reset();
        t_edges();
        t_level();
        t_bad_sel();
        t_mask();
        t_irq();
        t_coincide();
        t_filter();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule